// File: doc/BRIEF.md
# ALU condition flag register

The block sits beside an 8-bit ALU and keeps the processor status word. Each cycle it takes an operation code and two operands, forms the operation's result, and derives six arithmetic flags from that result: zero, carry (a borrow for subtraction), sign, signed overflow, half-carry and even parity. The flags are latched on the clock edge only when the flag-write enable is high. The latched carry is fed back into the next add-with-carry, subtract-with-borrow or rotate-through-carry operation, so multi-byte arithmetic and long rotates can be chained one byte at a time.

The status word also holds an interrupt-enable bit and a supervisor bit. When an interrupt is taken, the surrounding logic copies the status output into the save area in that same cycle, and the block then clears interrupt-enable. On return from the interrupt, the saved byte is presented on the restore input and reloaded whole. The branch unit reads the flags from the status output.

Top module: `flag_unit`

## Requirements
- R1: Zero (status bit 6) is set after a flag write whose result is 0x00 and is cleared after any other flag write.
- R2: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR and 7 rotate-left-through-carry. For codes 0 and 1 the result is a+b (plus the stored carry for code 1) modulo 256, and carry (bit 0) takes the unsigned carry out of bit 7.
- R3: For codes 2 and 3 the result is a-b (minus the stored carry for code 3) modulo 256, and carry is set exactly when a is less than b plus the carry that is subtracted, both taken as unsigned numbers.
- R4: Sign (bit 7) takes bit 7 of the result on every flag write.
- R5: Overflow (bit 1) is set for add when both operands have the same sign and the result's sign differs from it. It is set for subtract when the operands' signs differ and the result's sign differs from a.
- R6: Half-carry (bit 4) is the carry out of bit 3 for add and the borrow into bit 4 for subtract, with the stored carry included for codes 1 and 3.
- R7: Parity (bit 2) is 1 when the result has an even number of set bits and 0 when it has an odd number.
- R8: The logical codes 4 to 6 give a&b, a|b and a^b, and they clear carry, overflow and half-carry.
- R9: Code 7 gives {a[6:0], stored carry} as the result, ignores b, loads carry from a[7], and clears overflow and half-carry.
- R10: When flag_we is low, no flag changes. A flag write never changes interrupt-enable (bit 5) or supervisor (bit 3).
- R11: During the cycle in which int_enter is high, status shows the word in force before the interrupt. After the edge, interrupt-enable is 0 and supervisor is unchanged. A flag write in the same cycle still updates the arithmetic flags.
- R12: int_return loads restore_word into the whole status word at the edge. It overrides a flag write and an interrupt entry in the same cycle.
- R13: After a synchronous reset the status word is 0x08. Only supervisor is set. Bit order from bit 7 down is sign, zero, interrupt-enable, half-carry, supervisor, parity, overflow, carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code |
| a | input | 8 | First operand (minuend, rotate source) |
| b | input | 8 | Second operand |
| flag_we | input | 1 | Latch the arithmetic flags of this operation |
| int_enter | input | 1 | Interrupt taken this cycle |
| int_return | input | 1 | Return from interrupt, reload status word |
| restore_word | input | 8 | Saved status word to reload |
| result | output | 8 | Combinational result of the operation |
| status | output | 8 | Latched status word |

## Verification
A flag write can coincide with a status reload on return, and a flag write can coincide with an interrupt entry. The bench drives both in the same cycle. In the first case it also raises int_enter alongside a carry-producing add, and it checks that the next status equals the restore byte exactly. In the second case it expects the add's flags together with a cleared interrupt-enable and an unchanged supervisor bit. Carry chaining is judged by vector sequences in which the stored carry from one step changes the result of the next add-with-carry, subtract-with-borrow or rotate.

// File: rtl/flag_pkg.sv
package flag_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_RLC = 3'd7
    } op_e;

    // bit 7 down to bit 0
    typedef struct packed {
        logic s;
        logic z;
        logic ie;
        logic h;
        logic sup;
        logic p;
        logic v;
        logic c;
    } stat_t;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic p;
        logic v;
        logic c;
    } arith_t;

    localparam stat_t STAT_RESET = '{s: 1'b0, z: 1'b0, ie: 1'b0, h: 1'b0,
                                     sup: 1'b1, p: 1'b0, v: 1'b0, c: 1'b0};

    function automatic stat_t merge_arith(stat_t old, arith_t f);
        stat_t n;
        n   = old;
        n.s = f.s;
        n.z = f.z;
        n.h = f.h;
        n.p = f.p;
        n.v = f.v;
        n.c = f.c;
        return n;
    endfunction

    function automatic logic uses_carry(op_e o);
        return (o == OP_ADC) || (o == OP_SBB);
    endfunction

endpackage

// File: rtl/flag_calc.sv
module flag_calc
    import flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e            op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   result,
    output arith_t         flags
);
    localparam int HALF = W / 2;

    logic              cin;
    logic [W:0]        wide;
    logic [HALF:0]     low;
    logic [W-1:0]      r;
    logic              c_out;
    logic              h_out;
    logic              v_out;

    assign cin = uses_carry(op) ? c_in : 1'b0;

    always_comb begin
        wide  = '0;
        low   = '0;
        r     = '0;
        c_out = 1'b0;
        h_out = 1'b0;
        v_out = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                wide  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
                low   = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
                r     = wide[W-1:0];
                c_out = wide[W];
                h_out = low[HALF];
                v_out = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            OP_SUB, OP_SBB: begin
                wide  = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
                low   = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
                r     = wide[W-1:0];
                c_out = wide[W];
                h_out = low[HALF];
                v_out = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_XOR: r = a ^ b;
            OP_RLC: begin
                r     = {a[W-2:0], c_in};
                c_out = a[W-1];
            end
            default: r = '0;
        endcase
    end

    assign result  = r;
    assign flags.s = r[W-1];
    assign flags.z = (r == '0);
    assign flags.h = h_out;
    assign flags.p = ~^r;
    assign flags.v = v_out;
    assign flags.c = c_out;

endmodule

// File: rtl/flag_store.sv
module flag_store
    import flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  logic   enter,
    input  logic   ret,
    input  stat_t  reload,
    input  arith_t flags,
    output stat_t  word
);
    stat_t q;
    stat_t nxt;

    always_comb begin
        nxt = q;
        if (ret) begin
            nxt = reload;
        end else begin
            if (we) begin
                nxt = merge_arith(nxt, flags);
            end
            if (enter) begin
                nxt.ie = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= STAT_RESET;
        end else begin
            q <= nxt;
        end
    end

    assign word = q;

endmodule

// File: rtl/flag_unit.sv
module flag_unit
    import flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          flag_we,
    input  logic          int_enter,
    input  logic          int_return,
    input  logic [7:0]    restore_word,
    output logic [W-1:0]  result,
    output logic [7:0]    status
);
    stat_t  word;
    arith_t flags;

    flag_calc #(.W(W)) u_calc (
        .op     (op_e'(op)),
        .a      (a),
        .b      (b),
        .c_in   (word.c),
        .result (result),
        .flags  (flags)
    );

    flag_store u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (flag_we),
        .enter  (int_enter),
        .ret    (int_return),
        .reload (stat_t'(restore_word)),
        .flags  (flags),
        .word   (word)
    );

    assign status = word;

endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op,
    input logic          flag_we,
    input logic          int_enter,
    input logic          int_return,
    input logic [7:0]    restore_word,
    input logic [W-1:0]  result,
    input logic [7:0]    status
);
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !int_return) |=> (status[6] == ($past(result) == '0))); // R1
    AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !int_return) |=> (status[7] == $past(result[W-1]))); // R4
    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !int_return) |=> (status[2] == ($countones($past(result)) % 2 == 0))); // R7
    AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !int_return && op >= 3'd4 && op <= 3'd6) |=> (status[1:0] == 2'b00 && !status[4])); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && !int_enter && !int_return) |=> $stable(status)); // R10
    AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !int_enter && !int_return) |=> (status[5] == $past(status[5]) && status[3] == $past(status[3]))); // R10
    AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
        (int_enter && !int_return) |=> (!status[5] && status[3] == $past(status[3]))); // R11
    AST_RETURN_LOADS: assert property (@(posedge clk) disable iff (rst)
        int_return |=> (status == $past(restore_word))); // R12
endmodule

bind flag_unit flag_unit_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op           (op),
    .flag_we      (flag_we),
    .int_enter    (int_enter),
    .int_return   (int_return),
    .restore_word (restore_word),
    .result       (result),
    .status       (status)
);

// File: tb/tb_flag_unit.sv
module tb_flag_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op;
    logic [7:0] a, b;
    logic       flag_we, int_enter, int_return;
    logic [7:0] restore_word;
    logic [7:0] result;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flag_unit dut (
        .clk(clk), .rst(rst), .op(op), .a(a), .b(b),
        .flag_we(flag_we), .int_enter(int_enter), .int_return(int_return),
        .restore_word(restore_word), .result(result), .status(status)
    );

    // {op, a, b, expected result, expected status after the edge}
    localparam int NV = 16;
    localparam logic [34:0] VEC [0:NV-1] = '{
        {3'd0, 8'h0F, 8'h01, 8'h10, 8'h18},  // R2 R6 add, half-carry
        {3'd0, 8'h80, 8'h80, 8'h00, 8'h4F},  // R1 R2 R5 R7 carry, zero, overflow
        {3'd1, 8'h01, 8'h01, 8'h03, 8'h0C},  // R2 add-with-carry uses C=1
        {3'd0, 8'h7F, 8'h01, 8'h80, 8'h9A},  // R4 R5 positive overflow
        {3'd2, 8'h10, 8'h20, 8'hF0, 8'h8D},  // R3 borrow
        {3'd3, 8'h50, 8'h10, 8'h3F, 8'h1C},  // R3 R6 borrow-in, half borrow
        {3'd2, 8'h80, 8'h01, 8'h7F, 8'h1A},  // R5 subtract overflow
        {3'd2, 8'h00, 8'h01, 8'hFF, 8'h9D},  // R3 borrow, no overflow
        {3'd4, 8'hF0, 8'h3C, 8'h30, 8'h0C},  // R8 AND clears C
        {3'd5, 8'h00, 8'h00, 8'h00, 8'h4C},  // R8 OR zero
        {3'd6, 8'hAA, 8'h55, 8'hFF, 8'h8C},  // R8 XOR
        {3'd7, 8'h81, 8'hFF, 8'h02, 8'h09},  // R9 rotate, C from a[7]
        {3'd7, 8'h40, 8'hFF, 8'h81, 8'h8C},  // R9 rotate brings C in
        {3'd7, 8'h80, 8'h00, 8'h00, 8'h4D},  // R9 rotate to zero
        {3'd1, 8'hFF, 8'h00, 8'h00, 8'h5D},  // R2 R6 carry chain
        {3'd3, 8'h00, 8'h00, 8'hFF, 8'h9D}   // R3 R5 borrow chain, no V
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic we, input logic en, input logic rt, input logic [7:0] rw);
        op = o; a = x; b = y; flag_we = we; int_enter = en; int_return = rt; restore_word = rw;
    endtask

    task automatic idle_edge();
        @(posedge clk);
        @(negedge clk);
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R13 reset word", status, 8'h08);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][34:32], VEC[i][31:24], VEC[i][23:16], 1'b1, 1'b0, 1'b0, 8'h00);
            #1;
            check($sformatf("R2/R3/R8/R9 result vec %0d", i), result, VEC[i][15:8]);
            idle_edge();
            check($sformatf("R1/R4/R5/R6/R7 status vec %0d", i), status, VEC[i][7:0]);
        end

        // R10: no flag write, flags hold
        step(3'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00);
        idle_edge();
        check("R10 hold without write", status, 8'h9D);

        // R12: plain reload
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA5);
        idle_edge();
        check("R12 reload", status, 8'hA5);

        // R12: reload beats flag write and entry
        step(3'd0, 8'h80, 8'h80, 1'b1, 1'b1, 1'b1, 8'h28);
        idle_edge();
        check("R12 reload priority", status, 8'h28);

        // R10: flag write keeps IE and SUP
        step(3'd0, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0, 8'h00);
        idle_edge();
        check("R10 ie/sup kept", status, 8'h28);

        // R11: entry alone, save word visible in the entry cycle
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
        #1;
        check("R11 save word", status, 8'h28);
        idle_edge();
        check("R11 ie cleared", status, 8'h08);

        // R11: entry with flag write
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h28);
        idle_edge();
        step(3'd0, 8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 8'h00);
        idle_edge();
        check("R11 entry with flags", status, 8'h4F);

        // R13: reset again from a busy word
        step(3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF);
        idle_edge();
        rst = 1'b1;
        idle_edge();
        rst = 1'b0;
        check("R13 reset overrides", status, 8'h08);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule